// File: doc/BRIEF.md
# Shared PS/2 Serial Shift Engine

This block connects a controller to three PS/2 ports, each with its own clock and data line pair, through one hardware shift engine. Any port may hold a keyboard or a pointing device, and each port has its own enable. Firmware picks one enabled port and sets the engine to receive, transmit or bypass. In receive mode the engine takes in device-clocked frames through an 8-bit shift register. In transmit mode it runs the host-to-device request and sends a byte. It raises one interrupt when a transfer starts and another when the transfer ends. In bypass mode firmware drives the selected port's lines itself, reads their synchronised levels, and gets a flag plus an interrupt on every falling clock edge.

Line outputs are open-drain requests: 1 releases the line and 0 pulls it low. Every input line passes through a two-flop synchroniser. A falling device clock is the only timing event the engine uses. The request hold time and the stall timeout are counts of system cycles, set by parameters at integration.

Top module: `ps2_shift_hub`

## Requirements
- R1: After reset every clock and data output is 1 (released), all three interrupt outputs are 0, and STATUS (address 2) reads 0x00.
- R2: A port whose enable bit (CTRL bits 6:4, bit 4 = port 0) is 0 keeps both outputs at 1. Frames on it start no transfer, and its clock edges set no edge flag.
- R3: Receive mode (CTRL bits 1:0 = 1) takes a frame on the selected port (CTRL bits 3:2) made of start 0, eight data bits LSB first, odd parity, and stop 1. Each bit is sampled at a falling device clock. After the end interrupt, DATA (address 1) reads the byte.
- R4: A received frame with even parity sets STATUS bit 1. A stop bit of 0 sets STATUS bit 2. Either way the frame still ends with the end interrupt.
- R5: irq_start_o (STATUS bit 5) rises when a transfer begins. irq_end_o (STATUS bit 6) rises when it ends. Writing 1 to a STATUS bit from 1 to 7 clears it, and an uncleared flag stays set.
- R6: Transmit mode (CTRL bits 1:0 = 2) starts when DATA is written. The port clock is pulled low for exactly HOLD_CYC cycles with data low, then clock is released with data still low. After falling edges 1 to 10 the engine presents data bits LSB first, then odd parity, then a released stop. Data is sampled at falling edge 11 as the acknowledge, and a high acknowledge sets STATUS bit 4.
- R7: If no falling edge arrives on the selected port within TIMEOUT_CYC cycles during a bit phase, the transfer aborts. STATUS bit 3 and the end interrupt are set and the lines are released.
- R8: A CTRL write while STATUS bit 0 (busy) is 1 is ignored.
- R9: In bypass mode (CTRL bits 1:0 = 0), BYPASS (address 3) write bit 0 and bit 1 drive the selected enabled port's clock and data outputs. Read bits 0 and 1 return their synchronised levels. A falling clock on that port sets STATUS bit 7 and irq_edge_o.
- R10: Only the selected port is served. At most one port drives a line low, and frames on other ports are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 CTRL, 1 DATA, 2 STATUS, 3 BYPASS) |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| ps2_clk_i | input | NUM_CH | Sensed port clock lines |
| ps2_dat_i | input | NUM_CH | Sensed port data lines |
| ps2_clk_o | output | NUM_CH | Port clock drive, 0 pulls low |
| ps2_dat_o | output | NUM_CH | Port data drive, 0 pulls low |
| irq_start_o | output | 1 | Transfer-start interrupt |
| irq_end_o | output | 1 | Transfer-end interrupt |
| irq_edge_o | output | 1 | Bypass clock-edge interrupt |

## Verification
The bench targets parity and stop errors. A design that skipped these checks would report a clean status for a corrupt frame. The bench measures the transmit request's hold length cycle by cycle and checks that data is already low when clock is released, which catches an off-by-one hold counter. It sends frames on unselected and disabled ports, where a design that gated wrongly would start a transfer or set the edge flag. It also stalls a frame mid-way and tries to rewrite CTRL during a transmit, exposing a missing timeout or a control block that is not locked during a transfer.

// File: rtl/ps2_hub_pkg.sv
package ps2_hub_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_RX  = 2'd1,
    MODE_TX  = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_HOLD = 2'd2,
    ST_TX   = 2'd3
  } state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_BYP  = 2'd3;

  typedef struct packed {
    logic start;
    logic done;
    logic par_err;
    logic stop_err;
    logic tmo;
    logic ack_err;
  } evt_t;
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_line_i,
  input  logic dat_line_i,
  output logic clk_s_o,
  output logic dat_s_o,
  output logic fall_o
);
  logic [1:0] clk_ff, dat_ff;
  logic       clk_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_ff   <= 2'b11;
      dat_ff   <= 2'b11;
      clk_prev <= 1'b1;
    end else begin
      clk_ff   <= {clk_ff[0], clk_line_i};
      dat_ff   <= {dat_ff[0], dat_line_i};
      clk_prev <= clk_ff[1];
    end
  end

  assign clk_s_o = clk_ff[1];
  assign dat_s_o = dat_ff[1];
  assign fall_o  = clk_prev & ~clk_ff[1];
endmodule

// File: rtl/ps2_shift_fsm.sv
module ps2_shift_fsm
  import ps2_hub_pkg::*;
#(
  parameter int unsigned HOLD_CYC    = 5000,
  parameter int unsigned TIMEOUT_CYC = 20000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  mode_e      mode_i,
  input  logic       chan_ok_i,
  input  logic       fall_i,
  input  logic       dat_i,
  input  logic       tx_go_i,
  input  logic [7:0] tx_byte_i,
  output logic       busy_o,
  output logic       clk_drv_o,
  output logic       dat_drv_o,
  output logic [7:0] shreg_o,
  output evt_t       evt_o
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam int TMO_W  = $clog2(TIMEOUT_CYC + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);
  localparam logic [TMO_W-1:0]  TMO_LAST  = TMO_W'(TIMEOUT_CYC - 1);

  state_e            state_q;
  logic [3:0]        bit_q;
  logic [7:0]        shreg_q;
  logic              par_q;
  logic              dat_q;
  logic [HOLD_W-1:0] hold_q;
  logic [TMO_W-1:0]  tmo_q;
  evt_t              evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      dat_q   <= 1'b1;
      hold_q  <= '0;
      tmo_q   <= '0;
      evt_q   <= '0;
    end else begin
      evt_q <= '0;
      unique case (state_q)
        ST_IDLE: begin
          dat_q <= 1'b1;
          if (tx_go_i) begin
            shreg_q     <= tx_byte_i;
            par_q       <= ~^tx_byte_i;
            hold_q      <= '0;
            dat_q       <= 1'b0;
            state_q     <= ST_HOLD;
            evt_q.start <= 1'b1;
          end else if (mode_i == MODE_RX && chan_ok_i && fall_i && !dat_i) begin
            state_q     <= ST_RX;
            bit_q       <= 4'd1;
            tmo_q       <= '0;
            evt_q.start <= 1'b1;
          end
        end
        ST_RX: begin
          if (fall_i) begin
            tmo_q <= '0;
            bit_q <= bit_q + 4'd1;
            if (bit_q <= 4'd8) begin
              shreg_q <= {dat_i, shreg_q[7:1]};
            end else if (bit_q == 4'd9) begin
              par_q <= dat_i;
            end else begin
              evt_q.done     <= 1'b1;
              evt_q.par_err  <= ~(^{shreg_q, par_q});
              evt_q.stop_err <= ~dat_i;
              state_q        <= ST_IDLE;
            end
          end else if (tmo_q == TMO_LAST) begin
            evt_q.tmo  <= 1'b1;
            evt_q.done <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (hold_q == HOLD_LAST) begin
            state_q <= ST_TX;
            bit_q   <= '0;
            tmo_q   <= '0;
          end else begin
            hold_q <= hold_q + 1'b1;
          end
        end
        ST_TX: begin
          if (fall_i) begin
            tmo_q <= '0;
            bit_q <= bit_q + 4'd1;
            if (bit_q < 4'd8) begin
              dat_q   <= shreg_q[0];
              shreg_q <= {1'b0, shreg_q[7:1]};
            end else if (bit_q == 4'd8) begin
              dat_q <= par_q;
            end else if (bit_q == 4'd9) begin
              dat_q <= 1'b1;
            end else begin
              evt_q.done    <= 1'b1;
              evt_q.ack_err <= dat_i;
              dat_q         <= 1'b1;
              state_q       <= ST_IDLE;
            end
          end else if (tmo_q == TMO_LAST) begin
            evt_q.tmo  <= 1'b1;
            evt_q.done <= 1'b1;
            dat_q      <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign clk_drv_o = (state_q != ST_HOLD);
  assign dat_drv_o = dat_q;
  assign shreg_o   = shreg_q;
  assign evt_o     = evt_q;

  AST_TMO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RX || state_q == ST_TX) |-> tmo_q <= TMO_LAST); // R7
  AST_NO_START_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_o.start && evt_o.done)); // R5
  AST_ERR_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o.par_err || evt_o.stop_err || evt_o.tmo || evt_o.ack_err) |-> evt_o.done); // R4
  AST_RX_NEEDS_CHAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_RX) |-> $past(chan_ok_i)); // R2
endmodule

// File: rtl/ps2_hub_csr.sv
module ps2_hub_csr
  import ps2_hub_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              busy_i,
  input  evt_t              evt_i,
  input  logic              edge_ev_i,
  input  logic [7:0]        shreg_i,
  input  logic              sel_clk_i,
  input  logic              sel_dat_i,
  output mode_e             mode_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [NUM_CH-1:0] en_o,
  output logic              chan_ok_o,
  output logic              tx_go_o,
  output logic [7:0]        tx_byte_o,
  output logic              byp_clk_o,
  output logic              byp_dat_o,
  output logic              irq_start_o,
  output logic              irq_end_o,
  output logic              irq_edge_o
);
  localparam int CH_POW = 1 << SEL_W;
  localparam int EN_LSB = 2 + SEL_W;

  mode_e             mode_q;
  logic [SEL_W-1:0]  sel_q;
  logic [NUM_CH-1:0] en_q;
  logic              byp_clk_q, byp_dat_q;
  logic [7:1]        flag_q, flag_set, flag_clr;
  logic [CH_POW-1:0] en_ext;
  logic              ctrl_wr;

  assign ctrl_wr = wr_en_i && addr_i == ADDR_CTRL && !busy_i;
  assign en_ext  = CH_POW'(en_q);
  assign chan_ok_o = en_ext[sel_q];

  assign flag_set = {edge_ev_i, evt_i.done, evt_i.start, evt_i.ack_err,
                     evt_i.tmo, evt_i.stop_err, evt_i.par_err};
  assign flag_clr = (wr_en_i && addr_i == ADDR_STAT) ? wdata_i[7:1] : 7'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_OFF;
      sel_q     <= '0;
      en_q      <= '0;
      byp_clk_q <= 1'b1;
      byp_dat_q <= 1'b1;
      flag_q    <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_q <= mode_e'(wdata_i[1:0]);
        sel_q  <= wdata_i[2 +: SEL_W];
        en_q   <= wdata_i[EN_LSB +: NUM_CH];
      end
      if (wr_en_i && addr_i == ADDR_BYP) begin
        byp_clk_q <= wdata_i[0];
        byp_dat_q <= wdata_i[1];
      end
      flag_q <= (flag_q & ~flag_clr) | flag_set;
    end
  end

  assign tx_go_o   = wr_en_i && addr_i == ADDR_DATA && mode_q == MODE_TX
                     && !busy_i && chan_ok_o;
  assign tx_byte_o = wdata_i;

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = 8'({en_q, sel_q, mode_q});
      ADDR_DATA: rdata_o = shreg_i;
      ADDR_STAT: rdata_o = {flag_q, busy_i};
      default:   rdata_o = {6'd0, sel_dat_i, sel_clk_i};
    endcase
  end

  assign mode_o      = mode_q;
  assign sel_o       = sel_q;
  assign en_o        = en_q;
  assign byp_clk_o   = byp_clk_q;
  assign byp_dat_o   = byp_dat_q;
  assign irq_start_o = flag_q[5];
  assign irq_end_o   = flag_q[6];
  assign irq_edge_o  = flag_q[7];

  AST_CTRL_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_en_i && addr_i == ADDR_CTRL) |=> ($stable(mode_q) && $stable(sel_q) && $stable(en_q))); // R8
  AST_END_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_end_o && !(wr_en_i && addr_i == ADDR_STAT && wdata_i[6])) |=> irq_end_o); // R5
endmodule

// File: rtl/ps2_shift_hub.sv
module ps2_shift_hub
  import ps2_hub_pkg::*;
#(
  parameter int unsigned NUM_CH      = 3,
  parameter int unsigned HOLD_CYC    = 5000,
  parameter int unsigned TIMEOUT_CYC = 20000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [NUM_CH-1:0] ps2_clk_i,
  input  logic [NUM_CH-1:0] ps2_dat_i,
  output logic [NUM_CH-1:0] ps2_clk_o,
  output logic [NUM_CH-1:0] ps2_dat_o,
  output logic              irq_start_o,
  output logic              irq_end_o,
  output logic              irq_edge_o
);
  localparam int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CH_POW = 1 << SEL_W;

  logic [NUM_CH-1:0] clk_s, dat_s, fall;
  logic [CH_POW-1:0] clk_s_ext, dat_s_ext, fall_ext;
  mode_e             mode;
  logic [SEL_W-1:0]  sel;
  logic [NUM_CH-1:0] en;
  logic              chan_ok, tx_go, byp_clk, byp_dat;
  logic              busy, clk_drv, dat_drv, sel_fall, edge_ev;
  logic [7:0]        tx_byte, shreg;
  evt_t              evt;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_line
    ps2_line_sync u_sync (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clk_line_i (ps2_clk_i[c]),
      .dat_line_i (ps2_dat_i[c]),
      .clk_s_o    (clk_s[c]),
      .dat_s_o    (dat_s[c]),
      .fall_o     (fall[c])
    );
  end

  assign clk_s_ext = CH_POW'(clk_s);
  assign dat_s_ext = CH_POW'(dat_s);
  assign fall_ext  = CH_POW'(fall);
  assign sel_fall  = fall_ext[sel] & chan_ok;
  assign edge_ev   = sel_fall && mode == MODE_OFF;

  ps2_hub_csr #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_csr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .busy_i      (busy),
    .evt_i       (evt),
    .edge_ev_i   (edge_ev),
    .shreg_i     (shreg),
    .sel_clk_i   (clk_s_ext[sel]),
    .sel_dat_i   (dat_s_ext[sel]),
    .mode_o      (mode),
    .sel_o       (sel),
    .en_o        (en),
    .chan_ok_o   (chan_ok),
    .tx_go_o     (tx_go),
    .tx_byte_o   (tx_byte),
    .byp_clk_o   (byp_clk),
    .byp_dat_o   (byp_dat),
    .irq_start_o (irq_start_o),
    .irq_end_o   (irq_end_o),
    .irq_edge_o  (irq_edge_o)
  );

  ps2_shift_fsm #(.HOLD_CYC(HOLD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .chan_ok_i (chan_ok),
    .fall_i    (sel_fall),
    .dat_i     (dat_s_ext[sel]),
    .tx_go_i   (tx_go),
    .tx_byte_i (tx_byte),
    .busy_o    (busy),
    .clk_drv_o (clk_drv),
    .dat_drv_o (dat_drv),
    .shreg_o   (shreg),
    .evt_o     (evt)
  );

  always_comb begin
    ps2_clk_o = '1;
    ps2_dat_o = '1;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chan_ok && sel == SEL_W'(c)) begin
        ps2_clk_o[c] = (mode == MODE_OFF) ? byp_clk : clk_drv;
        ps2_dat_o[c] = (mode == MODE_OFF) ? byp_dat : dat_drv;
      end
    end
  end

  AST_DISABLED_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&(ps2_clk_o | en)) && (&(ps2_dat_o | en)))); // R2
  AST_SINGLE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~(ps2_clk_o & ps2_dat_o)) <= 1); // R10
endmodule

// File: tb/ps2_shift_hub_tb.sv
module ps2_shift_hub_tb;
  localparam int NCH  = 3;
  localparam int HOLD = 200;
  localparam int TMO  = 400;
  localparam int HALF = 20;

  typedef struct {
    logic [3:0] err;
    logic       chk_data;
    logic [7:0] data;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic [NCH-1:0] ps2_clk_o, ps2_dat_o, line_clk, line_dat;
  logic [NCH-1:0] dev_clk = '1, dev_dat = '1;
  logic irq_start_o, irq_end_o, irq_edge_o;

  int errors = 0, checks = 0, mon_done = 0, pushed = 0;
  exp_t exp_q[$];

  always #10 clk_i = ~clk_i;

  assign line_clk = ps2_clk_o & dev_clk;
  assign line_dat = ps2_dat_o & dev_dat;

  ps2_shift_hub #(.NUM_CH(NCH), .HOLD_CYC(HOLD), .TIMEOUT_CYC(TMO)) u_dut (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .ps2_clk_i(line_clk), .ps2_dat_i(line_dat), .ps2_clk_o, .ps2_dat_o,
    .irq_start_o, .irq_end_o, .irq_edge_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk_i);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // device-to-host frame; nbits < 11 leaves it stalled
  task automatic dev_frame(int ch, logic [7:0] b, logic par_flip, logic stop,
                           int nbits, logic exp_start, string req);
    logic [10:0] f;
    f = {stop, (~^b) ^ par_flip, b, 1'b0};
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk_i); dev_dat[ch] = f[i];
      idle(HALF);
      dev_clk[ch] = 1'b0;
      idle(HALF);
      if (i == 1) chk(req, irq_start_o, exp_start);
      dev_clk[ch] = 1'b1;
    end
    @(negedge clk_i); dev_dat[ch] = 1'b1;
  endtask

  // host-to-device receiver on port ch
  task automatic dev_tx(int ch, logic [7:0] b, logic ack);
    int cnt;
    logic [10:1] got;
    do @(negedge clk_i); while (ps2_clk_o[ch] === 1'b1);
    cnt = 0;
    while (ps2_clk_o[ch] === 1'b0) begin cnt++; @(negedge clk_i); end
    chk("R6 hold length", cnt, HOLD);
    chk("R6 data low at release", ps2_dat_o[ch], 1'b0);
    idle(HALF);
    for (int k = 1; k <= 11; k++) begin
      if (k == 11 && ack) begin dev_dat[ch] = 1'b0; idle(5); end
      dev_clk[ch] = 1'b0;
      idle(HALF);
      got[k] = line_dat[ch];
      dev_clk[ch] = 1'b1;
      idle(HALF);
      if (k == 11) dev_dat[ch] = 1'b1;
    end
    chk("R6 sent byte", got[8:1], b);
    chk("R6 sent parity odd", ^got[9:1], 1'b1);
    chk("R6 sent stop", got[10], 1'b1);
  endtask

  task automatic push(logic [3:0] e, logic cd, logic [7:0] d);
    exp_t x;
    x.err = e; x.chk_data = cd; x.data = d;
    exp_q.push_back(x);
    pushed++;
  endtask

  task automatic wait_mon();
    while (mon_done != pushed) @(negedge clk_i);
  endtask

  // monitor: pops expected result on each end interrupt (R5 end path)
  initial begin
    logic [7:0] s, d;
    exp_t x;
    forever begin
      @(posedge irq_end_o);
      rd(2'd2, s);
      if (exp_q.size() == 0) begin
        chk("R5 unexpected end", 1, 0);
      end else begin
        x = exp_q.pop_front();
        chk("R4/R6/R7 status errors", s[4:1], x.err);
        chk("R5 busy low at end", s[0], 1'b0);
        if (x.chk_data) begin
          rd(2'd1, d);
          chk("R3 received byte", d, x.data);
        end
      end
      wr(2'd2, 8'hFE);
      mon_done++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(3);
    chk("R1 clk out", ps2_clk_o, 3'b111);
    chk("R1 dat out", ps2_dat_o, 3'b111);
    chk("R1 irqs", {irq_start_o, irq_end_o, irq_edge_o}, 3'b000);
    rd(2'd2, v); chk("R1 status", v, 8'h00);
    rst_ni = 1'b1;
    idle(3);

    // receive on port 0, all enabled
    wr(2'd0, 8'h71);
    push(4'b0000, 1'b1, 8'hA5); dev_frame(0, 8'hA5, 0, 1, 11, 1, "R5 start irq"); wait_mon();
    push(4'b0000, 1'b1, 8'h00); dev_frame(0, 8'h00, 0, 1, 11, 1, "R3 start"); wait_mon();
    push(4'b0000, 1'b1, 8'hFF); dev_frame(0, 8'hFF, 0, 1, 11, 1, "R3 start"); wait_mon();
    push(4'b0001, 1'b0, 8'h00); dev_frame(0, 8'h3C, 1, 1, 11, 1, "R4 start"); wait_mon();
    push(4'b0010, 1'b0, 8'h00); dev_frame(0, 8'h81, 0, 0, 11, 1, "R4 start"); wait_mon();

    // R10: port 1 selected, frame on port 0 ignored
    wr(2'd0, 8'h75);
    dev_frame(0, 8'h12, 0, 1, 11, 0, "R10 other port no start");
    idle(10);
    rd(2'd2, v); chk("R10 no flags", v, 8'h00);
    push(4'b0000, 1'b1, 8'h5A); dev_frame(1, 8'h5A, 0, 1, 11, 1, "R10 selected start"); wait_mon();

    // R2: port 1 selected but disabled
    wr(2'd0, 8'h55);
    dev_frame(1, 8'h77, 0, 1, 11, 0, "R2 disabled no start");
    idle(10);
    rd(2'd2, v); chk("R2 no flags", v, 8'h00);
    chk("R2 released", {ps2_clk_o, ps2_dat_o}, 6'b111111);

    // R6 transmit on port 2, R8 lock during busy
    wr(2'd0, 8'h7A);
    push(4'b0000, 1'b0, 8'h00);
    fork
      dev_tx(2, 8'h96, 1'b1);
      begin
        wr(2'd1, 8'h96);
        wr(2'd0, 8'h71);
        rd(2'd0, v); chk("R8 ctrl locked", v, 8'h7A);
      end
    join
    wait_mon();
    push(4'b1000, 1'b0, 8'h00);
    fork
      dev_tx(2, 8'h01, 1'b0);
      wr(2'd1, 8'h01);
    join
    wait_mon();

    // R7 stalled receive on port 0
    wr(2'd0, 8'h71);
    push(4'b0100, 1'b0, 8'h00);
    dev_frame(0, 8'hC3, 0, 1, 3, 1, "R7 start");
    wait_mon();
    chk("R7 released", {ps2_clk_o, ps2_dat_o}, 6'b111111);

    // R9 bypass on port 0, only port 0 enabled
    wr(2'd0, 8'h10);
    wr(2'd3, 8'h02);
    idle(1);
    chk("R9 bypass clk drive", ps2_clk_o[0], 1'b0);
    chk("R9 bypass dat drive", ps2_dat_o[0], 1'b1);
    idle(4);
    rd(2'd3, v); chk("R9 bypass read", v, 8'h02);
    chk("R9 edge irq", irq_edge_o, 1'b1);
    wr(2'd3, 8'h03);
    idle(4);
    wr(2'd2, 8'hFE);
    dev_clk[1] = 1'b0; idle(6); dev_clk[1] = 1'b1; idle(6);
    chk("R2 disabled no edge", irq_edge_o, 1'b0);
    dev_clk[0] = 1'b0; idle(6); dev_clk[0] = 1'b1; idle(2);
    rd(2'd2, v); chk("R9 edge flag", v[7], 1'b1);
    chk("R5 edge is not a transfer", irq_start_o, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule